// File: doc/BRIEF.md
# Programmable truth-table I/O logic

This block sits between four I/O pins and the general-purpose I/O register logic. It can lay a small programmable lookup function over those pins. A two-bit mode field selects one of three behaviours:
- all four pins work as plain GPIO;
- two pins feed a 2-input lookup and a third pin drives the result;
- three pins feed a 3-input lookup and the fourth pin drives the result.

The result is read from an 8-bit truth-table register, so any combinational function of the selected inputs is available.

Pins taken over by the function get their direction from the mode, and the GPIO direction bits for them have no effect. A pin the function does not use keeps its normal GPIO path. Pad inputs are synchronised before use, and the lookup result is registered once before it drives the pad. The readback vector returns the synchronised pin values, and returns the registered function output on the function's output pin. Edge-detect logic fed from this readback can therefore raise interrupts on function inputs and on the function output alike.

Top module: `pin_logic_overlay`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, `rd_data` reads 0 and the registered function output is 0, whatever the pad inputs are.
- R2: With `lut_mode` = 2'b00, every pin is GPIO: `pad_oe` equals `gpio_dir` (1 = drive) and `pad_out` equals `gpio_dout`.
- R3: With `lut_mode` = 2'b01, pins 0 and 1 are undriven inputs and pin 2 is driven, while pin 3 keeps `gpio_dir[3]` as its drive enable.
- R4: With `lut_mode` = 2'b10, pins 0, 1 and 2 are undriven inputs and pin 3 is driven, whatever `gpio_dir` holds.
- R5: In mode 2'b01, `pad_out[2]` equals `lut_table[{pin1,pin0}]`. A change on the pads reaches `pad_out[2]` three clock edges later.
- R6: In mode 2'b10, `pad_out[3]` equals `lut_table[{pin2,pin1,pin0}]`, with the same three-edge latency as R5.
- R7: In mode 2'b01, pin 3 stays GPIO: `pad_out[3]` follows `gpio_dout[3]` and `pad_oe[3]` follows `gpio_dir[3]`.
- R8: For every pin that is not the function output, `rd_data[i]` equals the pad input of two clock edges earlier, in every mode.
- R9: On the function output pin (pin 2 in mode 2'b01, pin 3 in mode 2'b10), `rd_data` shows the registered function output, the same value as `pad_out` on that pin.
- R10: Mode 2'b11 is reserved and behaves exactly as mode 2'b00.
- R11: In mode 2'b01, `lut_table[7:4]` has no effect on `pad_out[2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_mode | input | 2 | 00 GPIO, 01 two-input function, 10 three-input function, 11 reserved (as 00) |
| lut_table | input | 8 | Truth table; bit n is the output for input index n |
| gpio_dir | input | 4 | GPIO drive enable per pin, 1 = output |
| gpio_dout | input | 4 | GPIO output data per pin |
| pad_in | input | 4 | Asynchronous pad input values |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad drive enables, 1 = drive |
| rd_data | output | 4 | Readback toward the data register |

## Verification
The hardest situation to reach from the ports is the point between the synchroniser and the result register. There, the readback already shows new input values, but the driven output pin still shows the result for the old inputs. A directed case holds the pads steady and then changes them at a negative edge. It samples after the second edge and again after the third, using a table with a single set bit, so that only one input combination gives a 1. Random stimulus then covers every mode, table and direction setting, with inputs held long enough to settle. A further directed case changes only the upper half of the table in two-input mode.

// File: rtl/pin_logic_pkg.sv
package pin_logic_pkg;

    localparam int PIN_COUNT     = 4;
    localparam int TABLE_BITS    = 8;
    localparam int INDEX_BITS    = $clog2(TABLE_BITS);
    localparam int LUT2_OUT_PIN  = 2;
    localparam int LUT3_OUT_PIN  = 3;

    typedef enum logic [1:0] {
        MODE_GPIO = 2'b00,
        MODE_LUT2 = 2'b01,
        MODE_LUT3 = 2'b10,
        MODE_RSVD = 2'b11
    } lut_mode_e;

    // Which pins the lookup function owns in a given mode
    typedef struct packed {
        logic [PIN_COUNT-1:0] as_input;
        logic [PIN_COUNT-1:0] as_output;
    } pin_claim_t;

    function automatic pin_claim_t claim_pins(lut_mode_e mode);
        pin_claim_t c;
        c.as_input  = '0;
        c.as_output = '0;
        unique case (mode)
            MODE_LUT2: begin
                c.as_input[0]            = 1'b1;
                c.as_input[1]            = 1'b1;
                c.as_output[LUT2_OUT_PIN] = 1'b1;
            end
            MODE_LUT3: begin
                c.as_input[0]            = 1'b1;
                c.as_input[1]            = 1'b1;
                c.as_input[2]            = 1'b1;
                c.as_output[LUT3_OUT_PIN] = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    // Truth-table index built from synchronised pin samples
    function automatic logic [INDEX_BITS-1:0] table_index(lut_mode_e mode,
                                                         logic [PIN_COUNT-1:0] pins);
        logic [INDEX_BITS-1:0] idx;
        unique case (mode)
            MODE_LUT2: idx = {1'b0, pins[1], pins[0]};
            MODE_LUT3: idx = {pins[2], pins[1], pins[0]};
            default:   idx = '0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/pin_logic_sync.sv
module pin_logic_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pin_logic_eval.sv
module pin_logic_eval
    import pin_logic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  lut_mode_e             mode,
    input  logic [TABLE_BITS-1:0] table_bits,
    input  logic [PIN_COUNT-1:0]  pins_sync,
    output logic                  result_q
);

    logic [INDEX_BITS-1:0] idx;
    logic                  result_d;

    always_comb begin
        idx      = table_index(mode, pins_sync);
        result_d = table_bits[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) result_q <= 1'b0;
        else     result_q <= result_d;
    end

endmodule

// File: rtl/pin_logic_route.sv
module pin_logic_route
    import pin_logic_pkg::*;
(
    input  lut_mode_e            mode,
    input  logic                 result_q,
    input  logic [PIN_COUNT-1:0] gpio_dir,
    input  logic [PIN_COUNT-1:0] gpio_dout,
    input  logic [PIN_COUNT-1:0] pins_sync,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] rd_data
);

    pin_claim_t claim;

    always_comb claim = claim_pins(mode);

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        always_comb begin
            if (claim.as_output[i]) begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = result_q;
                rd_data[i] = result_q;
            end else if (claim.as_input[i]) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = gpio_dout[i];
                rd_data[i] = pins_sync[i];
            end else begin
                pad_oe[i]  = gpio_dir[i];
                pad_out[i] = gpio_dout[i];
                rd_data[i] = pins_sync[i];
            end
        end
    end

endmodule

// File: rtl/pin_logic_overlay.sv
module pin_logic_overlay
    import pin_logic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            lut_mode,
    input  logic [TABLE_BITS-1:0] lut_table,
    input  logic [PIN_COUNT-1:0]  gpio_dir,
    input  logic [PIN_COUNT-1:0]  gpio_dout,
    input  logic [PIN_COUNT-1:0]  pad_in,
    output logic [PIN_COUNT-1:0]  pad_out,
    output logic [PIN_COUNT-1:0]  pad_oe,
    output logic [PIN_COUNT-1:0]  rd_data
);

    lut_mode_e            mode;
    logic [PIN_COUNT-1:0] pins_sync;
    logic                 result_q;

    assign mode = lut_mode_e'(lut_mode);

    pin_logic_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    pin_logic_eval u_eval (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .table_bits (lut_table),
        .pins_sync  (pins_sync),
        .result_q   (result_q)
    );

    pin_logic_route u_route (
        .mode      (mode),
        .result_q  (result_q),
        .gpio_dir  (gpio_dir),
        .gpio_dout (gpio_dout),
        .pins_sync (pins_sync),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/pin_logic_overlay_chk.sv
module pin_logic_overlay_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lut_mode,
    input logic [7:0] lut_table,
    input logic [3:0] gpio_dir,
    input logic [3:0] gpio_dout,
    input logic [3:0] pad_in,
    input logic [3:0] pad_out,
    input logic [3:0] pad_oe,
    input logic [3:0] rd_data
);

    logic [2:0] age;
    logic       armed;
    logic [3:0] pin_d1, pin_d2, pin_d3;
    logic [7:0] tbl_d1;
    logic [1:0] mode_d1;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 4)  age <= age + 3'd1;
        pin_d1  <= pad_in;
        pin_d2  <= pin_d1;
        pin_d3  <= pin_d2;
        tbl_d1  <= lut_table;
        mode_d1 <= lut_mode;
    end

    assign armed = (age == 3'd4);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == 4'b0000));

    // R2
    gpio_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b00) |-> (pad_oe == gpio_dir && pad_out == gpio_dout));

    // R10
    reserved_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b11) |-> (pad_oe == gpio_dir && pad_out == gpio_dout));

    // R3
    lut2_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b01) |-> (pad_oe[2:0] == 3'b100 && pad_oe[3] == gpio_dir[3]));

    // R4
    lut3_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b10) |-> (pad_oe == 4'b1000));

    // R5
    lut2_value_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && lut_mode == 2'b01 && mode_d1 == 2'b01)
        |-> (pad_out[2] == tbl_d1[{1'b0, pin_d3[1], pin_d3[0]}]));

    // R6
    lut3_value_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && lut_mode == 2'b10 && mode_d1 == 2'b10)
        |-> (pad_out[3] == tbl_d1[pin_d3[2:0]]));

    // R7
    lut2_spare_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b01) |-> (pad_out[3] == gpio_dout[3]));

    // R8
    readback_delay_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rd_data[1:0] == pin_d2[1:0]));

    // R9
    result_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_mode == 2'b01) |-> (rd_data[2] == pad_out[2]));

endmodule

bind pin_logic_overlay pin_logic_overlay_chk u_chk (.*);

// File: tb/pin_logic_overlay_bench.sv
module pin_logic_overlay_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] lut_mode;
    logic [7:0] lut_table;
    logic [3:0] gpio_dir;
    logic [3:0] gpio_dout;
    logic [3:0] pad_in;
    logic [3:0] pad_out;
    logic [3:0] pad_oe;
    logic [3:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5ns clk = ~clk;

    pin_logic_overlay u_pin_logic_overlay (
        .clk       (clk),
        .rst       (rst),
        .lut_mode  (lut_mode),
        .lut_table (lut_table),
        .gpio_dir  (gpio_dir),
        .gpio_dout (gpio_dout),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .rd_data   (rd_data)
    );

    function automatic logic m_lut(logic [1:0] m, logic [7:0] t, logic [3:0] p);
        case (m)
            2'b01:   return t[{1'b0, p[1], p[0]}];
            2'b10:   return t[p[2:0]];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] m_oe(logic [1:0] m, logic [3:0] d);
        case (m)
            2'b01:   return {d[3], 3'b100};
            2'b10:   return 4'b1000;
            default: return d;
        endcase
    endfunction

    function automatic logic [3:0] m_out(logic [1:0] m, logic [7:0] t, logic [3:0] o, logic [3:0] p);
        case (m)
            2'b01:   return {o[3], m_lut(m, t, p), o[1:0]};
            2'b10:   return {m_lut(m, t, p), o[2:0]};
            default: return o;
        endcase
    endfunction

    function automatic logic [3:0] m_rd(logic [1:0] m, logic [7:0] t, logic [3:0] p);
        case (m)
            2'b01:   return {p[3], m_lut(m, t, p), p[1:0]};
            2'b10:   return {m_lut(m, t, p), p[2:0]};
            default: return p;
        endcase
    endfunction

    task automatic check4(string tag, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic wait_edges(int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic full_check();
        string t_oe, t_out;
        case (lut_mode)
            2'b00: begin t_oe = "R2";  t_out = "R2";    end
            2'b11: begin t_oe = "R10"; t_out = "R10";   end
            2'b01: begin t_oe = "R3";  t_out = "R5/R7"; end
            default: begin t_oe = "R4"; t_out = "R6";   end
        endcase
        check4(t_oe, "pad_oe", pad_oe, m_oe(lut_mode, gpio_dir));
        check4(t_out, "pad_out", pad_out, m_out(lut_mode, lut_table, gpio_dout, pad_in));
        check4("R8/R9", "rd_data", rd_data, m_rd(lut_mode, lut_table, pad_in));
    endtask

    initial begin
        void'($urandom(32'd2417));
        rst       = 1'b1;
        lut_mode  = 2'b10;
        lut_table = 8'hFF;
        gpio_dir  = 4'h0;
        gpio_dout = 4'h0;
        pad_in    = 4'hF;
        wait_edges(3);
        // R1: reset clears readback and the registered result
        check4("R1", "rd_data in reset", rd_data, 4'b0000);
        check4("R1", "pad_out[3] in reset", {3'b000, pad_out[3]}, 4'b0000);

        // R6/R8 latency: only index 7 gives 1
        lut_table = 8'b1000_0000;
        pad_in    = 4'b0000;
        rst       = 1'b0;
        wait_edges(4);
        check4("R6", "settled low", {3'b000, pad_out[3]}, 4'b0000);
        pad_in = 4'b0111;
        wait_edges(2);
        check4("R8", "readback after two edges", rd_data[2:0], 3'b111);
        check4("R6", "output still old after two edges", {3'b000, pad_out[3]}, 4'b0000);
        wait_edges(1);
        check4("R6", "output after three edges", {3'b000, pad_out[3]}, 4'b0001);
        check4("R9", "readback of output pin", {3'b000, rd_data[3]}, 4'b0001);

        // R11: upper table half ignored in two-input mode
        lut_mode  = 2'b01;
        lut_table = 8'h0A;
        pad_in    = 4'b0001;
        wait_edges(4);
        check4("R11", "pad_out[2] base", {3'b000, pad_out[2]}, 4'b0001);
        lut_table = 8'hFA;
        wait_edges(4);
        check4("R11", "pad_out[2] upper set", {3'b000, pad_out[2]}, 4'b0001);
        lut_table = 8'h05;
        wait_edges(4);
        check4("R11", "pad_out[2] low half flipped", {3'b000, pad_out[2]}, 4'b0000);

        // R3/R7 directed: pin 3 follows GPIO settings
        gpio_dir  = 4'b1000;
        gpio_dout = 4'b1000;
        wait_edges(1);
        check4("R7", "pin3 GPIO in mode 01", {pad_oe[3], pad_out[3], 2'b00}, 4'b1100);
        check4("R3", "forced directions", pad_oe[2:0], 3'b100);

        // Random sweep over all modes
        for (int it = 0; it < 400; it++) begin
            lut_mode  = 2'($urandom_range(0, 3));
            lut_table = 8'($urandom);
            gpio_dir  = 4'($urandom);
            gpio_dout = 4'($urandom);
            pad_in    = 4'($urandom);
            wait_edges(4);
            full_check();
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule